// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a small binary counter meant to be chained into wider counters. It counts up or down, can be preset from a parallel data input, and can be held by an active-low enable. It produces two outputs for the next stage. `term_o` flags the end of the count range for the current direction. `ripple_no` is an active-low strobe that copies the count clock while the counter sits at its end value.

The whole block runs on one system clock. The external count clock `cp_i` is not used as a clock. It is sampled through a synchronizer chain, and each of its rising edges becomes a one-cycle step request. The counter register therefore moves three system-clock edges after `cp_i` rises. A parallel load is taken on every system edge while `load_ni` is low, and it wins over any step. The reset is asynchronous and active low.

Top module: `updn_cascade_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 at once, with no clock edge needed. The CP synchronizer and edge history are also cleared.
- R2: While `load_ni` is low, each system clock edge copies `data_i` into `count_o`. This takes priority over any count step, whatever the values of `cnt_en_ni` and `cp_i`.
- R3: While `cnt_en_ni` is high, rising edges of `cp_i` leave `count_o` unchanged.
- R4: With `dir_i` = 0 (up), `load_ni` high and `cnt_en_ni` low, each rising edge of `cp_i` adds one to `count_o`. The count wraps from 15 to 0. The new value appears on the third system clock edge after `cp_i` goes high.
- R5: With `dir_i` = 1 (down) and the other conditions of R4, each rising edge of `cp_i` subtracts one from `count_o`, wrapping from 0 to 15, with the same latency.
- R6: `term_o` is 1 exactly when `count_o` is 15 and `dir_i` = 0, or when `count_o` is 0 and `dir_i` = 1.
- R7: `term_o` follows a change of `dir_i` in the same cycle, with no clock edge, and does not depend on `cnt_en_ni`.
- R8: `ripple_no` is 0 only when `term_o` is 1, `cnt_en_ni` is 0 and the synchronized copy of `cp_i` is 0. In every other case it is 1.
- R9: A `cp_i` that stays high produces exactly one step. Each rising edge counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 4 | Parallel preset value |
| load_ni | input | 1 | Parallel load, active low |
| cnt_en_ni | input | 1 | Count enable, active low |
| dir_i | input | 1 | Direction: 0 counts up, 1 counts down |
| cp_i | input | 1 | External count clock, sampled as data |
| count_o | output | 4 | Counter value |
| term_o | output | 1 | End-of-range flag for the current direction |
| ripple_no | output | 1 | Active-low ripple strobe for the next stage |

## Verification
The assertions assume three things about the inputs. `cp_i` stays at each level for at least two system cycles, so that no edge is lost in the synchronizer. `cnt_en_ni` and `dir_i` do not change in the cycle in which a synchronized edge is consumed. `cp_i` is low when reset is released. The stimulus drives every input on the falling system edge. It holds each `cp_i` level for four system cycles and changes the enable and the direction only while `cp_i` has been low long enough for its synchronized copy to settle.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/cp_edge_sync.sv
module cp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cp_i,
  output logic cp_sync_o,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              hist_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[s] <= 1'b0;
          else         sync_q[s] <= cp_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sync_q[s] <= 1'b0;
          else         sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= sync_q[LAST];

  assign cp_sync_o = sync_q[LAST];
  assign rise_o    = sync_q[LAST] & ~hist_q;

  // one step per edge
  assert_single_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/updn_core.sv
module updn_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_ni,
  input  logic             cnt_en_ni,
  input  dir_e             dir_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] next_cnt;

  always_comb begin
    next_cnt = count_q;
    if (!load_ni)                     next_cnt = data_i;
    else if (step_i && !cnt_en_ni)
      next_cnt = (dir_i == DIR_DOWN) ? count_q - ONE : count_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) count_q <= '0;
    else         count_q <= next_cnt;

  assign count_o = count_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));
  assert_inhibit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && (cnt_en_ni || !step_i)) |=> $stable(count_o));
  assert_up_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_ni && step_i && dir_i == DIR_UP) |=> count_o == WIDTH'($past(count_o) + ONE));
  assert_down_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_ni && step_i && dir_i == DIR_DOWN) |=> count_o == WIDTH'($past(count_o) - ONE));
endmodule

// File: rtl/term_decode.sv
module term_decode
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  dir_e             dir_i,
  input  logic             cnt_en_ni,
  input  logic             cp_sync_i,
  output logic             term_o,
  output logic             ripple_no
);
  logic at_top, at_bottom;

  assign at_top    = &count_i;
  assign at_bottom = ~|count_i;
  assign term_o    = (dir_i == DIR_DOWN) ? at_bottom : at_top;
  assign ripple_no = ~(term_o & ~cnt_en_ni & ~cp_sync_i);

  always_comb begin
    assert_tc_range_R6: assert (!term_o || at_top || at_bottom);
    assert_rc_gate_R8:  assert (ripple_no || (term_o && !cnt_en_ni && !cp_sync_i));
  end
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             load_ni,
  input  logic             cnt_en_ni,
  input  logic             dir_i,
  input  logic             cp_i,
  output logic [WIDTH-1:0] count_o,
  output logic             term_o,
  output logic             ripple_no
);
  dir_e dir;
  logic cp_sync, step;

  assign dir = dir_e'(dir_i);

  cp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cp_i      (cp_i),
    .cp_sync_o (cp_sync),
    .rise_o    (step)
  );

  updn_core #(.WIDTH(WIDTH)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .load_ni   (load_ni),
    .cnt_en_ni (cnt_en_ni),
    .dir_i     (dir),
    .data_i    (data_i),
    .count_o   (count_o)
  );

  term_decode #(.WIDTH(WIDTH)) u_term (
    .count_i   (count_o),
    .dir_i     (dir),
    .cnt_en_ni (cnt_en_ni),
    .cp_sync_i (cp_sync),
    .term_o    (term_o),
    .ripple_no (ripple_no)
  );

  assert_reset_R1: assert property (@(posedge clk_i) !rst_ni |-> count_o == '0);
endmodule

// File: tb/sim_updn_cascade_counter.sv
module sim_updn_cascade_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] data = 4'd0;
  logic       load_n = 1'b1;
  logic       en_n = 1'b1;
  logic       dir = 1'b0;
  logic       cp = 1'b0;
  logic [3:0] count;
  logic       term;
  logic       ripple_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int ref_q = 0;

  always #10 clk = ~clk;

  updn_cascade_counter u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .load_ni(load_n),
    .cnt_en_ni(en_n), .dir_i(dir), .cp_i(cp), .count_o(count),
    .term_o(term), .ripple_no(ripple_n)
  );

  function automatic int exp_tc(int q, logic d);
    return d ? int'(q == 0) : int'(q == 15);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one CP period: high 4 cycles, low 4 cycles
  task automatic cp_pulse(string tag);
    cp = 1'b1;
    repeat (4) @(negedge clk);
    if (load_n == 1'b0) ref_q = data;
    else if (!en_n) ref_q = dir ? (ref_q + 15) % 16 : (ref_q + 1) % 16;
    chk({tag, " count"}, count, ref_q);
    chk("R8 rc high while cp high", ripple_n, 1);
    cp = 1'b0;
    repeat (4) @(negedge clk);
    chk({tag, " hold"}, count, ref_q);
    chk("R6 tc", term, exp_tc(ref_q, dir));
    chk("R8 rc while cp low", ripple_n, (exp_tc(ref_q, dir) && !en_n) ? 0 : 1);
  endtask

  task automatic load_val(int v);
    data = 4'(v);
    load_n = 1'b0;
    @(negedge clk);
    load_n = 1'b1;
    ref_q = v;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset count", count, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: load every value
    for (int v = 0; v < 16; v++) begin
      load_val(v);
      chk("R2 load", count, v);
    end

    // R4 / R5: a step from every value in both directions
    en_n = 1'b0;
    for (int d = 0; d < 2; d++) begin
      dir = d[0];
      for (int v = 0; v < 16; v++) begin
        load_val(v);
        repeat (3) @(negedge clk);
        cp_pulse(d ? "R5 down step" : "R4 up step");
      end
    end

    // R4 / R5: run through full wrap
    load_val(13);
    dir = 1'b0;
    for (int i = 0; i < 5; i++) cp_pulse("R4 up wrap");
    chk("R4 wrapped value", count, 2);
    dir = 1'b1;
    for (int i = 0; i < 4; i++) cp_pulse("R5 down wrap");
    chk("R5 wrapped value", count, 14);

    // R3: enable high blocks counting
    en_n = 1'b1;
    for (int i = 0; i < 3; i++) cp_pulse("R3 inhibit");
    chk("R3 unchanged", count, 14);

    // R7: tc follows dir immediately, independent of enable
    for (int v = 0; v < 16; v++) begin
      load_val(v);
      for (int e = 0; e < 2; e++) begin
        en_n = e[0];
        dir = 1'b0;
        #1;
        chk("R7 tc up", term, exp_tc(v, 1'b0));
        dir = 1'b1;
        #1;
        chk("R7 tc down", term, exp_tc(v, 1'b1));
        chk("R8 rc static", ripple_n, (exp_tc(v, 1'b1) && e == 0) ? 0 : 1);
        @(negedge clk);
      end
    end

    // R2: load overrides a live count step
    en_n = 1'b0;
    dir = 1'b0;
    load_val(5);
    data = 4'd9;
    load_n = 1'b0;
    cp_pulse("R2 load over count");
    load_n = 1'b1;
    @(negedge clk);
    chk("R2 override value", count, 9);

    // R9: long high cp counts once
    cp = 1'b1;
    repeat (12) @(negedge clk);
    chk("R9 single step", count, 10);
    cp = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 after release", count, 10);
    ref_q = 10;

    // R1: asynchronous reset between edges
    #3 rst_n = 1'b0;
    #1;
    chk("R1 async clear", count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stays cleared", count, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule